// File: doc/BRIEF.md
# Buck Switch PWM Generator with Control-Loop Tick

This block drives the power switch of a buck converter with a fixed-frequency pulse-width signal and supplies the control loop with a periodic tick. Each PWM period takes 256 clock cycles. A 2-bit fine counter steps every clock. A 6-bit coarse counter advances whenever the fine counter completes its four steps, and it restarts after it reaches the programmed period value of 63. With a 10 MHz clock this gives a switching rate of about 39.06 kHz.

An 8-bit duty word sets the high time in clock cycles. Its upper six bits are compared against the coarse counter and its two low bits against the fine counter, which gives quarter-step resolution within each coarse step. A new duty word is held in a pending register and takes effect only at the boundary of a period, so a partial pulse is never produced.

A one-cycle pulse marks the start of every period. A postscaler counts these period starts and raises a one-cycle loop tick on every eighth one. With a 10 MHz clock the tick rate is about 4883 Hz, which is the pace at which the regulation loop would recompute the duty.

Top module: `pwm_tick_gen`

## Requirements
- R1: A PWM period lasts exactly 256 clock cycles. `period_pulse` is high for exactly one cycle, the first cycle of each period, and the first such pulse comes 256 cycles after reset is released.
- R2: Number the cycles of a period from 0 to 255 as the position {coarse count, fine count}. `pwm_out` is high exactly when this position is below the active duty, so a duty of d gives d high cycles at positions 0 to d-1.
- R3: During reset and after it, `pwm_out`, `period_pulse` and `loop_tick` are low and the active duty is zero. `pwm_out` stays low until a nonzero duty has been loaded and has taken effect.
- R4: When `duty_load` is high, `duty_in` is captured in a pending register. The pending value becomes the active duty only at the next period start, so the period in progress keeps its old duty.
- R5: If `duty_load` is high in the last cycle of a period (position 255), the new duty governs the period that starts on the next cycle.
- R6: If several loads occur in one period, only the last one takes effect at the next period start.
- R7: `loop_tick` is high for one cycle, and it coincides with every eighth `period_pulse`. The first tick after reset comes with the eighth period pulse.
- R8: A duty of 255 keeps `pwm_out` low for exactly one cycle per period, at position 255. A duty of 0 keeps it low for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| duty_in | input | 8 | Requested duty in clock cycles per 256-cycle period |
| duty_load | input | 1 | Captures `duty_in` into the pending register |
| pwm_out | output | 1 | Drive signal for the power switch |
| period_pulse | output | 1 | One-cycle pulse at the start of each period |
| loop_tick | output | 1 | One-cycle pulse on every eighth period start |

## Verification
The bench loads a duty in the middle of a period and checks that the rest of that period still follows the old duty. A design without double buffering would show a runt pulse or an overly long pulse there. It also loads a duty in the very last cycle of a period. A design that let the wrap win over the load would apply that duty one period late. Duties 0, 1, 3, 4, 255 and values that cross coarse-step boundaries are measured by counting high cycles over a whole period. An error in how the fine bits are placed would move these counts off by one or by multiples of four. Finally, the ticks are counted against period pulses starting from reset. A postscaler that is off by one, or whose tick lasts more than one cycle, would show up in that count.

// File: rtl/pwm_tick_pkg.sv
// Package: shared widths and types of the PWM generator.
// Assumes the duty word splits into a coarse part and a fine part.
package pwm_tick_pkg;
    localparam int unsigned COARSE_W = 6;
    localparam int unsigned FINE_W   = 2;
    localparam int unsigned DUTY_W   = COARSE_W + FINE_W;
    typedef logic [DUTY_W-1:0] duty_t;
endpackage

// File: rtl/pwm_timebase.sv
// Module: pwm_timebase
// Free-running position counter. The fine count steps every clock, and the
// coarse count steps when the fine count wraps. The coarse count restarts
// after PERIOD. Flags the last cycle of a period (wrap) and pulses once at
// the first cycle of the next period.
// Assumes PERIOD fits in COARSE_W bits.
module pwm_timebase #(
    parameter int unsigned COARSE_W = 6,
    parameter int unsigned FINE_W   = 2,
    parameter int unsigned PERIOD   = 63
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [COARSE_W-1:0] coarse,
    output logic [FINE_W-1:0]   fine,
    output logic                wrap,
    output logic                period_pulse
);
    localparam logic [COARSE_W-1:0] LAST_COARSE = COARSE_W'(PERIOD);
    localparam logic [FINE_W-1:0]   LAST_FINE   = {FINE_W{1'b1}};

    logic [COARSE_W-1:0] coarse_q;
    logic [FINE_W-1:0]   fine_q;
    logic                pulse_q;
    logic                fine_last;

    // Decode the last fine step and the last cycle of the period.
    always_comb begin
        fine_last = (fine_q == LAST_FINE);
        wrap      = fine_last && (coarse_q == LAST_COARSE);
    end

    // Advance the counters and register the start-of-period pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coarse_q <= '0;
            fine_q   <= '0;
            pulse_q  <= 1'b0;
        end else begin
            fine_q  <= fine_q + 1'b1;
            pulse_q <= wrap;
            if (fine_last)
                coarse_q <= wrap ? '0 : coarse_q + 1'b1;
        end
    end

    assign coarse       = coarse_q;
    assign fine         = fine_q;
    assign period_pulse = pulse_q;

    // R1
    pulse_at_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_pulse |-> (coarse_q == '0 && fine_q == '0));
    // R1
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_pulse |=> !period_pulse);
endmodule

// File: rtl/pwm_duty_cmp.sv
// Module: pwm_duty_cmp
// Holds a pending and an active duty. The active duty is replaced only at
// a period wrap, and a load in the same cycle as the wrap goes straight
// through. The output is high while the position is below the active duty.
// Assumes position = {coarse, fine} and has the same width as the duty.
module pwm_duty_cmp #(
    parameter int unsigned DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty_in,
    input  logic              duty_load,
    input  logic              wrap,
    input  logic              period_pulse,
    input  logic [DUTY_W-1:0] position,
    output logic              pwm_out
);
    logic [DUTY_W-1:0] pending_q;
    logic [DUTY_W-1:0] active_q;

    // Capture new requests and promote them at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= '0;
            active_q  <= '0;
        end else begin
            if (duty_load)
                pending_q <= duty_in;
            if (wrap)
                active_q <= duty_load ? duty_in : pending_q;
        end
    end

    // Compare the running position with the active duty.
    always_comb pwm_out = (position < active_q);

    // R4
    duty_change_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_q) |-> period_pulse);
    // R8
    last_slot_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&position) |-> !pwm_out);
    // R3
    zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q == '0) |-> !pwm_out);
endmodule

// File: rtl/pwm_postscaler.sv
// Module: pwm_postscaler
// Counts period wraps and raises a one-cycle tick on every POST_DIV-th one.
// The tick lines up with the start-of-period pulse. Assumes POST_DIV >= 2.
module pwm_postscaler #(
    parameter int unsigned POST_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic period_pulse,
    output logic loop_tick
);
    localparam int unsigned          PS_W     = $clog2(POST_DIV);
    localparam logic [PS_W-1:0]      LAST_CNT = PS_W'(POST_DIV - 1);

    logic [PS_W-1:0] ps_q;
    logic            tick_q;

    // Count wraps and emit the tick on the last one of each group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q   <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= 1'b0;
            if (wrap) begin
                if (ps_q == LAST_CNT) begin
                    ps_q   <= '0;
                    tick_q <= 1'b1;
                end else begin
                    ps_q <= ps_q + 1'b1;
                end
            end
        end
    end

    assign loop_tick = tick_q;

    // R7
    tick_with_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_tick |-> period_pulse);
    // R7
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_tick |=> !loop_tick);
endmodule

// File: rtl/pwm_tick_gen.sv
// Module: pwm_tick_gen (top)
// PWM drive for a buck switch with a double-buffered duty and a control
// loop tick every POST_DIV periods. Assumes a synchronous active-low reset.
module pwm_tick_gen
    import pwm_tick_pkg::*;
#(
    parameter int unsigned PERIOD   = 63,
    parameter int unsigned POST_DIV = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty_in,
    input  logic              duty_load,
    output logic              pwm_out,
    output logic              period_pulse,
    output logic              loop_tick
);
    logic [COARSE_W-1:0] coarse;
    logic [FINE_W-1:0]   fine;
    logic                wrap;
    duty_t               position;

    pwm_timebase #(
        .COARSE_W (COARSE_W),
        .FINE_W   (FINE_W),
        .PERIOD   (PERIOD)
    ) u_timebase (
        .clk          (clk),
        .rst_n        (rst_n),
        .coarse       (coarse),
        .fine         (fine),
        .wrap         (wrap),
        .period_pulse (period_pulse)
    );

    assign position = {coarse, fine};

    pwm_duty_cmp #(
        .DUTY_W (DUTY_W)
    ) u_duty (
        .clk          (clk),
        .rst_n        (rst_n),
        .duty_in      (duty_in),
        .duty_load    (duty_load),
        .wrap         (wrap),
        .period_pulse (period_pulse),
        .position     (position),
        .pwm_out      (pwm_out)
    );

    pwm_postscaler #(
        .POST_DIV (POST_DIV)
    ) u_post (
        .clk          (clk),
        .rst_n        (rst_n),
        .wrap         (wrap),
        .period_pulse (period_pulse),
        .loop_tick    (loop_tick)
    );
endmodule

// File: tb/test_pwm_tick_gen.sv
// Bench for pwm_tick_gen: a table walk over duty values, then directed
// tests for reset, buffering, the load at the wrap cycle, and the tick.
module test_pwm_tick_gen;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] duty_in;
    logic       duty_load;
    logic       pwm_out, period_pulse, loop_tick;

    int n_cmp = 0;
    int n_bad = 0;

    localparam int NVEC = 8;
    localparam int VEC_DUTY [NVEC] = '{0, 1, 3, 4, 64, 131, 200, 255};
    localparam int VEC_HIGH [NVEC] = '{0, 1, 3, 4, 64, 131, 200, 255};

    pwm_tick_gen i_pwm_tick_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .duty_in      (duty_in),
        .duty_load    (duty_load),
        .pwm_out      (pwm_out),
        .period_pulse (period_pulse),
        .loop_tick    (loop_tick)
    );

    always #5 clk = ~clk;

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    // Advance to the next cycle that shows period_pulse (position 0).
    task automatic wait_period(output int cycles);
        cycles = 0;
        do begin
            cyc();
            cycles++;
        end while (!period_pulse && cycles < 400);
    endtask

    // Drive a load for one cycle, starting from the current sample point.
    task automatic load(int d);
        duty_in   = 8'(d);
        duty_load = 1'b1;
        cyc();
        duty_load = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int k, highs, ticks, pulses;
        rst_n = 1'b0; duty_in = 8'd0; duty_load = 1'b0;
        step(4);
        // R3 reset state
        chk("R3 pwm in reset", pwm_out, 0);
        chk("R3 pulse in reset", period_pulse, 0);
        chk("R3 tick in reset", loop_tick, 0);
        rst_n = 1'b1;

        // R1 first period length, R3 output low with zero duty
        k = 0; highs = 0;
        do begin
            cyc(); k++;
            if (pwm_out) highs++;
        end while (!period_pulse && k < 400);
        chk("R1 first period length", k, 256);
        chk("R3 no pwm before load", highs, 0);
        chk("R7 no tick on pulse 1", loop_tick, 0);
        cyc();
        chk("R1 pulse one cycle", period_pulse, 0);

        // R7 tick appears with the 8th period pulse
        ticks = 0;
        for (int p = 2; p <= 8; p++) begin
            wait_period(k);
            if (p < 8 && loop_tick) ticks++;
            if (p == 8) chk("R7 tick on pulse 8", loop_tick, 1);
        end
        chk("R7 no early tick", ticks, 0);
        cyc();
        chk("R7 tick one cycle", loop_tick, 0);

        // R7 exactly one tick per eight periods, R1 spacing
        ticks = 0; pulses = 0; k = 0;
        do begin
            cyc(); k++;
            if (period_pulse) pulses++;
            if (loop_tick) ticks++;
        end while (!loop_tick && k < 3000);
        chk("R7 cycles between ticks", k, 2047);
        chk("R7 pulses between ticks", pulses, 8);
        chk("R7 ticks counted", ticks, 1);

        // R2 R8 table walk: load, then measure one full period
        for (int v = 0; v < NVEC; v++) begin
            step(5);
            load(VEC_DUTY[v]);
            wait_period(k);
            highs = 0;
            chk("R2 level at position 0", pwm_out, (VEC_DUTY[v] > 0) ? 1 : 0);
            for (int i = 0; i < 256; i++) begin
                if (i > 0) cyc();
                if (pwm_out) highs++;
            end
            chk("R2 R8 high cycles per period", highs, VEC_HIGH[v]);
            chk("R8 low at position 255", pwm_out, 0);
        end

        // R4 mid-period load does not affect the current period
        step(3);
        load(128);
        wait_period(k);
        step(10);
        load(20);
        step(39);
        chk("R4 old duty kept at pos 50", pwm_out, 1);
        wait_period(k);
        step(19);
        chk("R4 new duty at pos 19", pwm_out, 1);
        step(11);
        chk("R4 new duty at pos 30", pwm_out, 0);

        // R5 load in the wrap cycle applies to the starting period
        wait_period(k);
        step(255);
        load(7);
        chk("R5 pulse after wrap load", period_pulse, 1);
        chk("R5 pwm at pos 0", pwm_out, 1);
        step(6);
        chk("R5 pwm at pos 6", pwm_out, 1);
        cyc();
        chk("R5 pwm at pos 7", pwm_out, 0);

        // R6 last load in a period wins
        wait_period(k);
        step(3);
        load(40);
        load(9);
        wait_period(k);
        step(8);
        chk("R6 pwm at pos 8", pwm_out, 1);
        cyc();
        chk("R6 pwm at pos 9", pwm_out, 0);
        step(11);
        chk("R6 pwm at pos 20", pwm_out, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule